// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block forms a physical address from a selected segment register and an effective offset. It has two translation modes, and a mode input picks between them on every cycle. In real mode the 16-bit value held in the chosen segment register is multiplied by sixteen and added to the low 16 bits of the offset. The 20-bit result wraps at 1 MB. In protected mode each segment register carries a hidden cache that holds a base, a limit and two access attributes. The offset is checked against that limit and those attributes, and on success it is added to the cached base. The sum wraps at the top of the configured physical space.

A single write port loads one segment register per cycle. In real mode a write also fills the hidden cache from the written value, so protected code starts from a consistent state. In protected mode the base, limit and attributes come from the port. A translate request gives its result one clock later: either a valid address or a fault flag. The fault flag comes with a cause code and the number of the segment register that caused the fault. The defaults give the narrow configuration: four segment registers, a 24-bit physical space and 16-bit offsets. Setting NSEG=6, PA_W=32 and OFF_W=32 gives the wide configuration.

Top module: `seg_xlate`

## Requirements
- R1: After synchronous reset, out_valid, out_fault, out_addr, out_fault_seg and out_cause are all zero. Every segment register holds value 0, base 0, limit 0xFFFF (zero-extended to OFF_W) and both attributes clear.
- R2: In real mode (prot_mode=0), a request to register s with offset o yields address ((sel[s] * 16) + o[15:0]) mod 2^20, zero-extended to PA_W.
- R3: The real-mode sum drops its carry out of bit 19: register value 0xFFFF with offset 0xFFFF gives 0x0FFEF. Real-mode addresses never exceed 0xFFFFF.
- R4: A write in real mode stores wr_sel and sets that register's base to wr_sel*16, its limit to 0xFFFF and both attributes to clear. wr_base, wr_limit, wr_ro and wr_xo are ignored.
- R5: In protected mode a request that passes its checks yields (base[s] + o) mod 2^PA_W.
- R6: In protected mode, if o + req_size > limit[s] (computed without wrap, where req_size is access bytes minus one), the request faults with cause 1 (limit).
- R7: In protected mode a request faults with cause 2 (access) in two cases: req_write=1 to a register with ro or xo set, or a data read (req_write=0, req_fetch=0) from a register with xo set. A fetch from an xo register is allowed. A limit fault takes precedence over an access fault.
- R8: A request naming register index NSEG or above faults with cause 3 (index) in either mode. Writes to such indices change nothing.
- R9: On a fault, out_fault=1, out_valid=0, out_addr=0 and out_fault_seg equals the requested index, all in the same cycle.
- R10: Results appear exactly one clock after the request. A cycle without a request gives out_valid=0, out_fault=0, out_addr=0, out_fault_seg=0 and out_cause=0.
- R11: A request in the same cycle as a write to the same register is translated with the register contents from before the write.
- R12: In real mode no limit or access check is made: attributes and limits have no effect on the address, and only the index check can fault.
- R13: A write in protected mode loads wr_sel, wr_base, wr_limit, wr_ro and wr_xo into the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_mode | input | 1 | 1 selects protected translation and write behaviour |
| wr_en | input | 1 | Segment register write strobe |
| wr_seg | input | 3 | Index of register to write |
| wr_sel | input | 16 | Segment value to store |
| wr_base | input | PA_W | Cached base (protected-mode writes) |
| wr_limit | input | OFF_W | Cached limit (protected-mode writes) |
| wr_ro | input | 1 | Read-only attribute (protected-mode writes) |
| wr_xo | input | 1 | Execute-only attribute (protected-mode writes) |
| req_valid | input | 1 | Translate request |
| req_seg | input | 3 | Index of register to translate through |
| req_off | input | OFF_W | Effective offset |
| req_size | input | 2 | Access bytes minus one |
| req_write | input | 1 | Request is a write |
| req_fetch | input | 1 | Request is an instruction fetch |
| out_valid | output | 1 | Registered: translated address is valid |
| out_addr | output | PA_W | Registered physical address, zero when not valid |
| out_fault | output | 1 | Registered fault flag |
| out_fault_seg | output | 3 | Index of the faulting register |
| out_cause | output | 2 | 0 none, 1 limit, 2 access, 3 index |

## Verification
The hardest state to reach from the ports is a segment register whose cache no longer matches its value: a protected-mode load with a small limit and execute-only set, followed by a return to real mode. Only then does a real-mode request show that limits and attributes are ignored. The stimulus builds this state on purpose. It also aims offsets just below, at and just past the cached limit with every access size, and it issues requests in the same cycle as writes to the same register. A long random phase then mixes modes, writes and requests, and a behavioural reference model is compared on every clock.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_LIMIT  = 2'd1,
    CAUSE_ACCESS = 2'd2,
    CAUSE_INDEX  = 2'd3
  } cause_e;

  typedef struct packed {
    logic ro;
    logic xo;
  } seg_attr_t;

  localparam int SEG_IDX_W  = 3;
  localparam int SEG_VAL_W  = 16;
  localparam int REAL_PA_W  = 20;
  localparam int REAL_OFF_W = 16;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_xlate_pkg::*;
#(
  parameter int NSEG  = 4,
  parameter int PA_W  = 24,
  parameter int OFF_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [SEG_IDX_W-1:0] widx,
  input  logic [SEG_VAL_W-1:0] wsel,
  input  logic [PA_W-1:0]      wbase,
  input  logic [OFF_W-1:0]     wlim,
  input  seg_attr_t            wattr,
  input  logic [SEG_IDX_W-1:0] ridx,
  output logic                 ridx_ok,
  output logic [SEG_VAL_W-1:0] rsel,
  output logic [PA_W-1:0]      rbase,
  output logic [OFF_W-1:0]     rlim,
  output seg_attr_t            rattr
);

  localparam int IX_W = (NSEG > 1) ? $clog2(NSEG) : 1;
  localparam logic [OFF_W-1:0] RST_LIM = OFF_W'(16'hFFFF);

  logic [SEG_VAL_W-1:0] sel_q  [NSEG];
  logic [PA_W-1:0]      base_q [NSEG];
  logic [OFF_W-1:0]     lim_q  [NSEG];
  seg_attr_t            attr_q [NSEG];

  logic            widx_ok;
  logic [IX_W-1:0] rix;

  assign widx_ok = (32'(widx) < NSEG);
  assign ridx_ok = (32'(ridx) < NSEG);
  assign rix     = ridx_ok ? ridx[IX_W-1:0] : '0;

  for (genvar i = 0; i < NSEG; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        sel_q[i]  <= '0;
        base_q[i] <= '0;
        lim_q[i]  <= RST_LIM;
        attr_q[i] <= '0;
      end else if (we && widx_ok && (widx[IX_W-1:0] == IX_W'(i))) begin
        sel_q[i]  <= wsel;
        base_q[i] <= wbase;
        lim_q[i]  <= wlim;
        attr_q[i] <= wattr;
      end
    end
  end

  always_comb begin
    rsel  = sel_q[rix];
    rbase = base_q[rix];
    rlim  = lim_q[rix];
    rattr = attr_q[rix];
  end

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  logic             prot,
  input  logic             idx_ok,
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       size_m1,
  input  logic [OFF_W-1:0] lim,
  input  seg_attr_t        attr,
  input  logic             is_write,
  input  logic             is_fetch,
  output cause_e           cause
);

  localparam int EXT_W = OFF_W + 2;

  logic [EXT_W-1:0] last_byte;
  logic             lim_bad;
  logic             acc_bad;

  assign last_byte = EXT_W'(off) + EXT_W'(size_m1);
  assign lim_bad   = last_byte > EXT_W'(lim);
  assign acc_bad   = (is_write && (attr.ro || attr.xo)) ||
                     (!is_write && !is_fetch && attr.xo);

  always_comb begin
    if (!idx_ok)       cause = CAUSE_INDEX;
    else if (!prot)    cause = CAUSE_NONE;
    else if (lim_bad)  cause = CAUSE_LIMIT;
    else if (acc_bad)  cause = CAUSE_ACCESS;
    else               cause = CAUSE_NONE;
  end

endmodule

// File: rtl/seg_adder.sv
module seg_adder
  import seg_xlate_pkg::*;
#(
  parameter int PA_W  = 24,
  parameter int OFF_W = 16
) (
  input  logic                 prot,
  input  logic [SEG_VAL_W-1:0] sel,
  input  logic [PA_W-1:0]      base,
  input  logic [OFF_W-1:0]     off,
  output logic [PA_W-1:0]      addr
);

  logic [REAL_PA_W-1:0] real_sum;
  logic [PA_W-1:0]      prot_sum;

  assign real_sum = {sel, 4'b0000} + REAL_PA_W'(off[REAL_OFF_W-1:0]);
  assign prot_sum = base + PA_W'(off);
  assign addr     = prot ? prot_sum : PA_W'(real_sum);

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int NSEG  = 4,
  parameter int PA_W  = 24,
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             prot_mode,
  input  logic             wr_en,
  input  logic [2:0]       wr_seg,
  input  logic [15:0]      wr_sel,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [OFF_W-1:0] wr_limit,
  input  logic             wr_ro,
  input  logic             wr_xo,
  input  logic             req_valid,
  input  logic [2:0]       req_seg,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_size,
  input  logic             req_write,
  input  logic             req_fetch,
  output logic             out_valid,
  output logic [PA_W-1:0]  out_addr,
  output logic             out_fault,
  output logic [2:0]       out_fault_seg,
  output logic [1:0]       out_cause
);

  localparam logic [OFF_W-1:0] REAL_LIM = OFF_W'(16'hFFFF);

  // Write-side cache fill: real mode derives the cache from the value
  logic [PA_W-1:0]  wbase_eff;
  logic [OFF_W-1:0] wlim_eff;
  seg_attr_t        wattr_eff;

  assign wbase_eff = prot_mode ? wr_base  : PA_W'({wr_sel, 4'b0000});
  assign wlim_eff  = prot_mode ? wr_limit : REAL_LIM;
  assign wattr_eff = prot_mode ? seg_attr_t'({wr_ro, wr_xo}) : seg_attr_t'(2'b00);

  logic                 rd_ok;
  logic [SEG_VAL_W-1:0] rd_sel;
  logic [PA_W-1:0]      rd_base;
  logic [OFF_W-1:0]     rd_lim;
  seg_attr_t            rd_attr;

  seg_regfile #(.NSEG(NSEG), .PA_W(PA_W), .OFF_W(OFF_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_en),
    .widx   (wr_seg),
    .wsel   (wr_sel),
    .wbase  (wbase_eff),
    .wlim   (wlim_eff),
    .wattr  (wattr_eff),
    .ridx   (req_seg),
    .ridx_ok(rd_ok),
    .rsel   (rd_sel),
    .rbase  (rd_base),
    .rlim   (rd_lim),
    .rattr  (rd_attr)
  );

  cause_e chk_cause;

  seg_check #(.OFF_W(OFF_W)) u_check (
    .prot    (prot_mode),
    .idx_ok  (rd_ok),
    .off     (req_off),
    .size_m1 (req_size),
    .lim     (rd_lim),
    .attr    (rd_attr),
    .is_write(req_write),
    .is_fetch(req_fetch),
    .cause   (chk_cause)
  );

  logic [PA_W-1:0] sum_addr;

  seg_adder #(.PA_W(PA_W), .OFF_W(OFF_W)) u_add (
    .prot(prot_mode),
    .sel (rd_sel),
    .base(rd_base),
    .off (req_off),
    .addr(sum_addr)
  );

  logic hit_fault;
  assign hit_fault = req_valid && (chk_cause != CAUSE_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_addr      <= '0;
      out_fault     <= 1'b0;
      out_fault_seg <= '0;
      out_cause     <= CAUSE_NONE;
    end else begin
      out_valid     <= req_valid && !hit_fault;
      out_addr      <= (req_valid && !hit_fault) ? sum_addr : '0;
      out_fault     <= hit_fault;
      out_fault_seg <= hit_fault ? req_seg : '0;
      out_cause     <= hit_fault ? chk_cause : CAUSE_NONE;
    end
  end

  // R9: a fault never carries an address
  p_fault_excl_r9: assert property (@(posedge clk) disable iff (rst)
    out_fault |-> (!out_valid && (out_addr == '0)));

  // R9: fault code names the register requested one cycle earlier
  p_fault_seg_r9: assert property (@(posedge clk) disable iff (rst)
    out_fault |-> (out_fault_seg == $past(req_seg)));

  // R10: no request, no result on the next cycle
  p_latency_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(req_valid) |-> (!out_valid && !out_fault));

  // R10: cause stays zero outside faults
  p_cause_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !out_fault |-> (out_cause == 2'd0));

  // R3: real-mode results stay inside 1 MB
  p_real_1mb_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(prot_mode)) |-> ((out_addr >> REAL_PA_W) == '0));

  // R12: real mode only faults on a bad index
  p_real_nochk_r12: assert property (@(posedge clk) disable iff (rst)
    (out_fault && !$past(prot_mode)) |-> (out_cause == 2'd3));

endmodule

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;
  localparam int NSEG  = 4;
  localparam int PA_W  = 24;
  localparam int OFF_W = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst = 1'b1;
  logic             prot_mode = 1'b0;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_seg = '0;
  logic [15:0]      wr_sel = '0;
  logic [PA_W-1:0]  wr_base = '0;
  logic [OFF_W-1:0] wr_limit = '0;
  logic             wr_ro = 1'b0, wr_xo = 1'b0;
  logic             req_valid = 1'b0;
  logic [2:0]       req_seg = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic [1:0]       req_size = '0;
  logic             req_write = 1'b0, req_fetch = 1'b0;
  logic             out_valid, out_fault;
  logic [PA_W-1:0]  out_addr;
  logic [2:0]       out_fault_seg;
  logic [1:0]       out_cause;

  seg_xlate #(.NSEG(NSEG), .PA_W(PA_W), .OFF_W(OFF_W)) dut (.*);

  // Reference model state
  longint unsigned m_sel [8];
  longint unsigned m_base[8];
  longint unsigned m_lim [8];
  bit              m_ro  [8];
  bit              m_xo  [8];

  logic            e_valid, e_fault;
  logic [PA_W-1:0] e_addr;
  logic [2:0]      e_seg;
  logic [1:0]      e_cause;

  int    vectors = 0, miscompares = 0;
  string tag = "R1";
  bit    chk_en = 1'b0, done = 1'b0;

  always @(posedge clk) begin
    bit v, f;
    longint unsigned a, last;
    int c;
    v = 0; f = 0; a = 0; c = 0;
    if (rst) begin
      for (int i = 0; i < 8; i++) begin
        m_sel[i] = 0; m_base[i] = 0; m_lim[i] = 16'hFFFF; m_ro[i] = 0; m_xo[i] = 0;
      end
    end else begin
      if (req_valid) begin
        if (req_seg >= NSEG) begin f = 1; c = 3; end
        else if (!prot_mode) begin
          a = (m_sel[req_seg] * 16 + longint'(req_off)) % (64'd1 << 20);
          v = 1;
        end else begin
          last = longint'(req_off) + longint'(req_size);
          if (last > m_lim[req_seg]) begin f = 1; c = 1; end
          else if ((req_write && (m_ro[req_seg] || m_xo[req_seg])) ||
                   (!req_write && !req_fetch && m_xo[req_seg])) begin f = 1; c = 2; end
          else begin
            a = (m_base[req_seg] + longint'(req_off)) % (64'd1 << PA_W);
            v = 1;
          end
        end
      end
      if (wr_en && wr_seg < NSEG) begin
        m_sel[wr_seg] = wr_sel;
        if (prot_mode) begin
          m_base[wr_seg] = wr_base; m_lim[wr_seg] = wr_limit;
          m_ro[wr_seg] = wr_ro; m_xo[wr_seg] = wr_xo;
        end else begin
          m_base[wr_seg] = longint'(wr_sel) * 16; m_lim[wr_seg] = 16'hFFFF;
          m_ro[wr_seg] = 0; m_xo[wr_seg] = 0;
        end
      end
    end
    e_valid <= v;
    e_fault <= f;
    e_addr  <= PA_W'(a);
    e_seg   <= f ? req_seg : 3'd0;
    e_cause <= 2'(c);
  end

  always @(negedge clk) begin
    if (chk_en && !done) begin
      vectors++;
      if (out_valid !== e_valid || out_fault !== e_fault || out_addr !== e_addr ||
          out_fault_seg !== e_seg || out_cause !== e_cause) begin
        miscompares++;
        $display("FAIL %s: got v=%0b f=%0b addr=%h seg=%0d cause=%0d, expected v=%0b f=%0b addr=%h seg=%0d cause=%0d",
                 tag, out_valid, out_fault, out_addr, out_fault_seg, out_cause,
                 e_valid, e_fault, e_addr, e_seg, e_cause);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0; wr_en = 0;
    end
  endtask

  task automatic mode(input logic p);
    @(negedge clk);
    prot_mode = p; req_valid = 0; wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] s, input logic [15:0] o, input logic [1:0] sz,
                    input logic w, input logic fe);
    @(negedge clk);
    wr_en = 0; req_valid = 1; req_seg = s; req_off = o; req_size = sz;
    req_write = w; req_fetch = fe;
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] sel, input logic [23:0] b,
                    input logic [15:0] lim, input logic ro, input logic xo);
    @(negedge clk);
    req_valid = 0; wr_en = 1; wr_seg = s; wr_sel = sel; wr_base = b;
    wr_limit = lim; wr_ro = ro; wr_xo = xo;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk_en = 1;
    @(negedge clk); rst = 0;
    // R1: idle after reset, then reset caches seen through protected mode
    tag = "R1"; idle(3);
    mode(1);
    for (int s = 0; s < NSEG; s++) rd(3'(s), 16'hFFFF, 2'd0, 1'b1, 1'b0);
    rd(3'd0, 16'hFFFF, 2'd1, 1'b0, 1'b0);
    mode(0);
    // R2: real-mode sums
    tag = "R2";
    wr(3'd0, 16'h1234, 24'hABCDEF, 16'h0001, 1, 1);
    wr(3'd1, 16'h0010, 0, 0, 0, 0);
    rd(3'd0, 16'h0005, 2'd0, 0, 0);
    rd(3'd1, 16'h8001, 2'd3, 1, 0);
    rd(3'd3, 16'h0000, 2'd0, 0, 1);
    // R3: wrap at 1 MB
    tag = "R3";
    wr(3'd2, 16'hFFFF, 0, 0, 0, 0);
    rd(3'd2, 16'hFFFF, 2'd0, 0, 0);
    rd(3'd2, 16'h0010, 2'd0, 0, 0);
    rd(3'd2, 16'h000F, 2'd0, 0, 0);
    // R4: real-mode write fills cache, ignores cache inputs
    tag = "R4";
    wr(3'd3, 16'h1234, 24'h777777, 16'h0003, 1, 1);
    mode(1);
    rd(3'd3, 16'hFFFF, 2'd0, 1, 0);
    rd(3'd3, 16'hFFFF, 2'd1, 0, 0);
    rd(3'd3, 16'h0000, 2'd0, 0, 0);
    // R13 / R5: protected loads and wrap at PA_W
    tag = "R13";
    wr(3'd0, 16'h0008, 24'h100000, 16'h0FFF, 0, 0);
    rd(3'd0, 16'h0123, 2'd1, 1, 0);
    tag = "R5";
    wr(3'd1, 16'h0010, 24'hFFFF00, 16'hFFFF, 0, 0);
    rd(3'd1, 16'h0150, 2'd0, 0, 0);
    rd(3'd1, 16'h00FF, 2'd0, 0, 0);
    // R6: limit boundaries
    tag = "R6";
    wr(3'd2, 16'h0018, 24'h002000, 16'h00FF, 0, 0);
    rd(3'd2, 16'h00FF, 2'd0, 0, 0);
    rd(3'd2, 16'h00FE, 2'd1, 0, 0);
    rd(3'd2, 16'h00FE, 2'd2, 0, 0);
    rd(3'd2, 16'h00FC, 2'd3, 0, 0);
    rd(3'd2, 16'h00FD, 2'd3, 0, 0);
    rd(3'd1, 16'hFFFF, 2'd3, 0, 0);
    // R7: access rights and precedence
    tag = "R7";
    wr(3'd2, 16'h0018, 24'h002000, 16'h00FF, 1, 0);
    rd(3'd2, 16'h0010, 2'd0, 1, 0);
    rd(3'd2, 16'h0010, 2'd0, 0, 0);
    wr(3'd3, 16'h0020, 24'h030000, 16'h00FF, 0, 1);
    rd(3'd3, 16'h0010, 2'd0, 0, 0);
    rd(3'd3, 16'h0010, 2'd0, 0, 1);
    rd(3'd3, 16'h0010, 2'd0, 1, 0);
    rd(3'd3, 16'h0100, 2'd0, 1, 0);
    // R8: bad indices, both modes
    tag = "R8";
    rd(3'd4, 16'h0000, 2'd0, 0, 0);
    rd(3'd7, 16'h0010, 2'd0, 1, 0);
    wr(3'd5, 16'hAAAA, 24'h123456, 16'h0000, 1, 1);
    rd(3'd0, 16'h0000, 2'd0, 0, 0);
    mode(0);
    rd(3'd6, 16'h0000, 2'd0, 0, 0);
    // R9 / R10: back-to-back fault then valid, and gaps
    tag = "R9";
    mode(1);
    rd(3'd3, 16'h0010, 2'd0, 0, 0);
    rd(3'd3, 16'h0010, 2'd0, 0, 1);
    tag = "R10";
    idle(2);
    rd(3'd1, 16'h0001, 2'd0, 0, 0);
    idle(1);
    // R11: request and write to the same register together
    tag = "R11";
    @(negedge clk);
    wr_en = 1; wr_seg = 3'd1; wr_sel = 16'h0040; wr_base = 24'h500000; wr_limit = 16'h0000;
    wr_ro = 1; wr_xo = 0;
    req_valid = 1; req_seg = 3'd1; req_off = 16'h0200; req_size = 2'd0; req_write = 1; req_fetch = 0;
    rd(3'd1, 16'h0200, 2'd0, 1, 0);
    rd(3'd1, 16'h0000, 2'd0, 0, 0);
    // R12: real mode ignores stale limits and attributes
    tag = "R12";
    mode(0);
    rd(3'd1, 16'h0200, 2'd3, 1, 0);
    rd(3'd3, 16'hFFF0, 2'd3, 0, 0);
    rd(3'd2, 16'h8000, 2'd1, 1, 0);
    // Random mixed traffic
    tag = "R2/R5/R6/R7 random";
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if ($urandom_range(0, 31) == 0) prot_mode = ~prot_mode;
      wr_en     = ($urandom_range(0, 5) == 0);
      wr_seg    = 3'($urandom_range(0, 5));
      wr_sel    = 16'($urandom);
      wr_base   = 24'($urandom);
      wr_limit  = ($urandom_range(0, 1) == 0) ? 16'($urandom_range(0, 511)) : 16'($urandom);
      wr_ro     = 1'($urandom);
      wr_xo     = ($urandom_range(0, 3) == 0);
      req_valid = ($urandom_range(0, 3) != 0);
      req_seg   = 3'($urandom_range(0, 4));
      req_off   = ($urandom_range(0, 1) == 0) ? 16'($urandom_range(0, 600)) : 16'($urandom);
      req_size  = 2'($urandom);
      req_write = 1'($urandom);
      req_fetch = 1'($urandom);
    end
    idle(3);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: got no completion, expected end of stimulus");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule